// File: doc/BRIEF.md
# Application Type Lock Controller

This block decides whether a signed secure application may be started, and which class of application the platform is locked to. It keeps a type register with four values: general (no lock) and three application classes A, B and C. It also keeps an enrolled flag and a running flag. A start request carries the requested class and a signature-valid bit from an external verifier. It is compared with the class recorded alongside the stored image and with the class currently locked in. The block answers with a one-cycle grant pulse or a one-cycle reject pulse with a reason code.

The lock is write-once until a reboot. The first granted start while the register holds general records that class. From then on only starts of the same class are allowed. A reboot releases the lock unless the running application has been enrolled. An enrolled lock survives reboots and is released only when a factory-reset strobe is followed by a reboot.

Top module: `app_lock_ctrl`

## Requirements
- R1: After reset the type output is general (code 0), the enrolled and running outputs are 0, and no grant or reject pulse is present.
- R2: A start request with the signature-valid bit low is refused with reason code 1. This check takes priority over every other check.
- R3: A signed start whose requested class differs from the image class is refused with reason code 2.
- R4: While the type register holds general, a signed start of class A (1), B (2) or C (3) that matches the image class is granted. The class is recorded and the running output goes to 1.
- R5: While a non-general class is recorded, a start of a different class, or a request for class 0, is refused with reason code 3. A start of the recorded class is granted.
- R6: Grant and reject appear in the cycle after the request and are never high together. Each is a single-cycle pulse. A refused start leaves the type and enrolled outputs unchanged. The reason code reads 0 whenever reject is low.
- R7: A reboot strobe clears running. If the enrolled flag is 0, it also returns the type to general.
- R8: An enrollment strobe sets the enrolled flag only while a non-general class is recorded and an application is running. Otherwise it has no effect.
- R9: With enrolled set, a reboot keeps the recorded class. A factory-reset strobe alone changes nothing visible. The first reboot after a factory-reset strobe returns the type to general and clears enrolled.
- R10: A reboot strobe takes precedence over a start or enrollment strobe in the same cycle. Those strobes produce no grant, no reject and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start request strobe |
| start_type | input | 2 | Requested application class |
| sig_ok | input | 1 | Signature of the start request verified |
| image_type | input | 2 | Class recorded with the stored image |
| enroll_stb | input | 1 | Enrollment strobe |
| factory_stb | input | 1 | Factory-reset strobe |
| reboot_stb | input | 1 | Reboot strobe |
| grant | output | 1 | Start granted (one-cycle pulse) |
| reject | output | 1 | Start refused (one-cycle pulse) |
| reject_code | output | 2 | Reason for refusal: 1 signature, 2 image mismatch, 3 lock mismatch |
| cur_type | output | 2 | Currently recorded class |
| enrolled | output | 1 | Enrollment flag |
| app_running | output | 1 | An application has been started since the last reboot |

## Verification
The block has no tunable sizes. The bench builds it with the fixed 2-bit class encoding, so every value of requested class, image class and signature bit can be applied exhaustively. These combinations are applied from both the unlocked state and each locked class. Directed sequences cover the enrollment gate, the factory-reset-then-reboot release, and strobes that collide with a reboot in the same cycle.

// File: rtl/app_lock_pkg.sv
package app_lock_pkg;

  localparam int TYPE_W = 2;
  localparam int CODE_W = 2;

  typedef logic [TYPE_W-1:0] app_type_t;

  localparam app_type_t TYPE_GENERAL = '0;

  typedef enum logic [CODE_W-1:0] {
    RSN_NONE  = 2'd0,
    RSN_SIG   = 2'd1,
    RSN_IMAGE = 2'd2,
    RSN_LOCK  = 2'd3
  } reason_t;

  // Ordered checks: signature, image class, then lock class.
  function automatic reason_t judge_start(input logic      sig_ok,
                                          input app_type_t req,
                                          input app_type_t img,
                                          input app_type_t locked);
    reason_t r;
    if (!sig_ok)                                     r = RSN_SIG;
    else if (req != img)                             r = RSN_IMAGE;
    else if (req == TYPE_GENERAL)                    r = RSN_LOCK;
    else if (locked != TYPE_GENERAL && req != locked) r = RSN_LOCK;
    else                                             r = RSN_NONE;
    return r;
  endfunction

  // Type the register takes after a granted start.
  function automatic app_type_t type_after_grant(input app_type_t locked,
                                                 input app_type_t req);
    return (locked == TYPE_GENERAL) ? req : locked;
  endfunction

endpackage

// File: rtl/app_start_judge.sv
module app_start_judge
  import app_lock_pkg::*;
(
  input  logic      start_req,
  input  logic      reboot_stb,
  input  logic      sig_ok,
  input  app_type_t req_type,
  input  app_type_t img_type,
  input  app_type_t locked_type,
  output logic      accept,
  output logic      refuse,
  output reason_t   reason
);

  reason_t verdict;

  always_comb begin
    verdict = judge_start(sig_ok, req_type, img_type, locked_type);
    accept  = 1'b0;
    refuse  = 1'b0;
    reason  = RSN_NONE;
    if (start_req && !reboot_stb) begin
      if (verdict == RSN_NONE) begin
        accept = 1'b1;
      end else begin
        refuse = 1'b1;
        reason = verdict;
      end
    end
  end

endmodule

// File: rtl/app_type_store.sv
module app_type_store
  import app_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reboot_stb,
  input  logic      factory_stb,
  input  logic      enroll_stb,
  input  logic      accept,
  input  logic      refuse,
  input  app_type_t req_type,
  output app_type_t type_q,
  output logic      enrolled_q,
  output logic      running_q
);

  logic factory_pend_q;
  logic enroll_ok;
  logic release_lock;

  assign enroll_ok    = enroll_stb && !reboot_stb && (type_q != TYPE_GENERAL) && running_q;
  assign release_lock = reboot_stb && (!enrolled_q || factory_pend_q || factory_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q         <= TYPE_GENERAL;
      enrolled_q     <= 1'b0;
      running_q      <= 1'b0;
      factory_pend_q <= 1'b0;
    end else if (reboot_stb) begin
      running_q      <= 1'b0;
      factory_pend_q <= 1'b0;
      if (release_lock) begin
        type_q     <= TYPE_GENERAL;
        enrolled_q <= 1'b0;
      end
    end else begin
      if (factory_stb) factory_pend_q <= 1'b1;
      if (enroll_ok)   enrolled_q     <= 1'b1;
      if (accept) begin
        type_q    <= type_after_grant(type_q, req_type);
        running_q <= 1'b1;
      end
    end
  end

  // R6
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> ($stable(type_q) && $stable(enrolled_q)));

  // R7
  reboot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reboot_stb && !enrolled_q) |=> (type_q == TYPE_GENERAL && !running_q));

  // R8
  enroll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enroll_stb && !enrolled_q && (type_q == TYPE_GENERAL || !running_q)) |=> !enrolled_q);

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (type_q != TYPE_GENERAL && !reboot_stb) |=> (type_q == $past(type_q)));

endmodule

// File: rtl/app_lock_ctrl.sv
module app_lock_ctrl
  import app_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic [1:0] start_type,
  input  logic       sig_ok,
  input  logic [1:0] image_type,
  input  logic       enroll_stb,
  input  logic       factory_stb,
  input  logic       reboot_stb,
  output logic       grant,
  output logic       reject,
  output logic [1:0] reject_code,
  output logic [1:0] cur_type,
  output logic       enrolled,
  output logic       app_running
);

  logic      ev_accept;
  logic      ev_refuse;
  reason_t   ev_reason;
  app_type_t type_q;
  logic      enrolled_q;
  logic      running_q;
  logic      grant_q;
  logic      reject_q;
  reason_t   code_q;

  app_start_judge u_judge (
    .start_req   (start_req),
    .reboot_stb  (reboot_stb),
    .sig_ok      (sig_ok),
    .req_type    (start_type),
    .img_type    (image_type),
    .locked_type (type_q),
    .accept      (ev_accept),
    .refuse      (ev_refuse),
    .reason      (ev_reason)
  );

  app_type_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .reboot_stb  (reboot_stb),
    .factory_stb (factory_stb),
    .enroll_stb  (enroll_stb),
    .accept      (ev_accept),
    .refuse      (ev_refuse),
    .req_type    (start_type),
    .type_q      (type_q),
    .enrolled_q  (enrolled_q),
    .running_q   (running_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
      code_q   <= RSN_NONE;
    end else begin
      grant_q  <= ev_accept;
      reject_q <= ev_refuse;
      code_q   <= ev_reason;
    end
  end

  assign grant       = grant_q;
  assign reject      = reject_q;
  assign reject_code = code_q;
  assign cur_type    = type_q;
  assign enrolled    = enrolled_q;
  assign app_running = running_q;

  // R6
  grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));

  // R6
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reject |-> (reject_code == 2'd0));

  // R2
  bad_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !sig_ok && !reboot_stb) |=> (reject && reject_code == 2'd1));

  // R10
  reboot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_stb |=> (!grant && !reject && !app_running));

  // R4
  grant_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (app_running && cur_type != 2'd0));

endmodule

// File: tb/test_app_lock_ctrl.sv
module test_app_lock_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic [1:0] start_type = 2'd0;
  logic       sig_ok = 1'b0;
  logic [1:0] image_type = 2'd0;
  logic       enroll_stb = 1'b0;
  logic       factory_stb = 1'b0;
  logic       reboot_stb = 1'b0;
  logic       grant;
  logic       reject;
  logic [1:0] reject_code;
  logic [1:0] cur_type;
  logic       enrolled;
  logic       app_running;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // reference state
  int m_type = 0, m_enr = 0, m_run = 0, m_pend = 0;
  int m_grant = 0, m_rej = 0, m_code = 0;

  always #10 clk = ~clk;

  app_lock_ctrl i_app_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_type(start_type),
    .sig_ok(sig_ok), .image_type(image_type), .enroll_stb(enroll_stb),
    .factory_stb(factory_stb), .reboot_stb(reboot_stb), .grant(grant),
    .reject(reject), .reject_code(reject_code), .cur_type(cur_type),
    .enrolled(enrolled), .app_running(app_running)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "grant", int'(grant), m_grant);
    check(tag, "reject", int'(reject), m_rej);
    check(tag, "reject_code", int'(reject_code), m_code);
    check(tag, "cur_type", int'(cur_type), m_type);
    check(tag, "enrolled", int'(enrolled), m_enr);
    check(tag, "app_running", int'(app_running), m_run);
  endtask

  task automatic model(input bit s, input int rt, input bit sg, input int it,
                       input bit en, input bit fr, input bit rb);
    m_grant = 0; m_rej = 0; m_code = 0;
    if (rb) begin
      m_run = 0;
      if (m_enr == 0 || m_pend == 1 || fr) begin
        m_type = 0;
        m_enr = 0;
      end
      m_pend = 0;
    end else begin
      int old_run = m_run;
      int old_type = m_type;
      if (fr) m_pend = 1;
      if (en && old_type != 0 && old_run == 1) m_enr = 1;
      if (s) begin
        if (!sg) m_code = 1;
        else if (rt != it) m_code = 2;
        else if (rt == 0) m_code = 3;
        else if (old_type != 0 && rt != old_type) m_code = 3;
        if (m_code != 0) m_rej = 1;
        else begin
          m_grant = 1;
          m_run = 1;
          if (old_type == 0) m_type = rt;
        end
      end
    end
  endtask

  task automatic step(input string tag, input bit s, input int rt, input bit sg,
                      input int it, input bit en, input bit fr, input bit rb);
    start_req = s; start_type = rt[1:0]; sig_ok = sg; image_type = it[1:0];
    enroll_stb = en; factory_stb = fr; reboot_stb = rb;
    model(s, rt, sg, it, en, fr, rb);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    compare_all("R1");
    idle("R1");

    // R2 bad signature, even with a class mismatch present
    step("R2", 1, 1, 0, 2, 0, 0, 0);
    idle("R6");
    // R3 image class mismatch
    step("R3", 1, 1, 1, 2, 0, 0, 0);
    // R4 first grant records class A
    step("R4", 1, 1, 1, 1, 0, 0, 0);
    idle("R6");
    // R5 other class refused, same class granted, class 0 refused
    step("R5", 1, 2, 1, 2, 0, 0, 0);
    step("R5", 1, 1, 1, 1, 0, 0, 0);
    step("R5", 1, 0, 1, 0, 0, 0, 0);
    // R6 bad signature while locked leaves state alone
    step("R6", 1, 1, 0, 1, 0, 0, 0);
    // R7 reboot without enrollment releases
    step("R7", 0, 0, 0, 0, 0, 0, 1);
    // R8 enrollment ignored while general
    step("R8", 0, 0, 0, 0, 1, 0, 0);
    idle("R8");
    // R8 enrollment accepted while locked and running
    step("R4", 1, 3, 1, 3, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0);
    // R9 reboot keeps class, factory alone changes nothing, then release
    step("R9", 0, 0, 0, 0, 0, 0, 1);
    step("R9", 1, 2, 1, 2, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 0);
    idle("R9");
    step("R9", 0, 0, 0, 0, 0, 0, 1);
    idle("R9");
    // R8 enrollment ignored when locked but not running: lock and enroll first
    step("R4", 1, 2, 1, 2, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 1, 0, 0);
    // R9 factory strobe concurrent with reboot releases at that reboot
    step("R9", 0, 0, 0, 0, 0, 1, 1);
    // R10 reboot wins over start and enroll
    step("R10", 1, 1, 1, 1, 1, 0, 1);
    step("R10", 1, 2, 0, 2, 0, 0, 1);
    idle("R10");

    // exhaustive sweep from unlocked and each locked class
    for (int lk = 0; lk < 4; lk++) begin
      for (int rt = 0; rt < 4; rt++) begin
        for (int it = 0; it < 4; it++) begin
          for (int sg = 0; sg < 2; sg++) begin
            if (lk != 0) step("R4", 1, lk, 1, lk, 0, 0, 0);
            step("R5", 1, rt, sg[0], it, 0, 0, 0);
            step("R3", 0, 0, 0, 0, 0, 0, 0);
            step("R7", 0, 0, 0, 0, 0, 0, 1);
          end
        end
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule